// File: doc/BRIEF.md
# Clock Group Ratio Selector with Test Bypass and Tristate Control

This block produces seven clock groups (processor, memory, hub, PCI, USB, reference and interrupt-controller) from one fast input clock. The input models a synthesizer output in normal operation and an externally applied test clock in test mode. Every group is an integer divider of that clock. A three-bit select input chooses between three modes: a quiet mode that releases the pads, a bypass test mode with fixed ratios, and run mode. In run mode two of the select bits pick the processor and memory ratios.

One extra control bit lets the memory group move to its faster ratio, but only when the processor runs at its fastest ratio. This switch reloads the memory divider on its own, at a point where its output is low and its count has wrapped. No other divider restarts. Any change of mode or speed selection restarts every divider from a common phase, so the slower groups stay aligned to the hub group.

Top module: `clk_fsdiv`

## Requirements
- R1: With fsSel[2]=0 and fsSel[0]=0 (fsSel[1] of any value), outEn is 0 and every clock output is held low.
- R2: With fsSel[2]=0 and fsSel[0]=1 (fsSel[1] ignored), outEn is 1 and the outputs divide clk by: cpu 2, sdram 2, hub 3, pci 6, usb 2, ref 1 (the input clock itself), apic 6.
- R3: With fsSel[2]=1, the processor ratio follows {fsSel[0],fsSel[1]}: 00 gives 6, 10 gives 4, 01 gives 3, 11 gives 3 (default parameters).
- R4: In run mode the memory ratio is 4 for codes 00 and 10 and 3 for code 01, with sdramFast having no effect on these codes. For code 11 it is 4 when sdramFast=0 and 3 when sdramFast=1.
- R5: In run mode the hub, pci, apic, usb and ref ratios are 6, 12, 12, 8 and 28 for every speed code.
- R6: Every output with ratio N is high for N half-periods of clk out of each 2N, odd ratios included.
- R7: Rising edges of pci and apic coincide, and each coincides with a rising edge of hub.
- R8: Toggling sdramFast under code 11 restarts no divider. The cpu, hub, pci, apic, usb and ref waveforms keep their period and duty unchanged. The memory divider takes its new ratio only while sdramClk is low.
- R9: While rst is high, every clock output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock (synthesizer model or test clock) |
| rst | input | 1 | Synchronous active-high reset |
| fsSel | input | 3 | Mode and speed select: [2] run enable, [1] and [0] speed code |
| sdramFast | input | 1 | Requests the faster memory ratio under code 11 |
| cpuClk | output | 1 | Processor group clock |
| sdramClk | output | 1 | Memory group clock |
| hubClk | output | 1 | Hub group clock |
| pciClk | output | 1 | PCI group clock |
| usbClk | output | 1 | USB group clock |
| refClk | output | 1 | Reference group clock |
| apicClk | output | 1 | Interrupt-controller group clock |
| outEn | output | 1 | Shared pad enable, low in quiet mode |

## Verification
The bench builds the block with its default ratios. These defaults cover every divider variant: an odd ratio of 3 with the dual-edge extension, even ratios from 2 to 28, and the divide-by-one bypass in test mode. The defaults are small enough that each group completes several whole cycles inside every configuration window. The bench samples twice per input clock, so high time and period are measured in half-periods. Under these ratios this exposes duty errors on odd ratios, missing alignment between the hub, pci and apic edges, and any disturbance to other groups while the memory ratio changes.

// File: rtl/clk_fsdiv_pkg.sv
`timescale 1ns/1ps
package clk_fsdiv_pkg;
  localparam int RW = 8;
  localparam int NGRP = 7;
  typedef logic [RW-1:0] ratio_t;
  typedef logic [NGRP-1:0][RW-1:0] ratioSet_t;

  // group slots
  localparam int G_CPU  = 0;
  localparam int G_MEM  = 1;
  localparam int G_HUB  = 2;
  localparam int G_PCI  = 3;
  localparam int G_USB  = 4;
  localparam int G_REF  = 5;
  localparam int G_APIC = 6;

  // fixed bypass-test ratios
  localparam ratio_t T_CPU  = ratio_t'(2);
  localparam ratio_t T_MEM  = ratio_t'(2);
  localparam ratio_t T_HUB  = ratio_t'(3);
  localparam ratio_t T_PCI  = ratio_t'(6);
  localparam ratio_t T_USB  = ratio_t'(2);
  localparam ratio_t T_REF  = ratio_t'(1);
  localparam ratio_t T_APIC = ratio_t'(6);

  typedef enum logic [1:0] {
    MODE_TRI  = 2'd0,
    MODE_TEST = 2'd1,
    MODE_RUN  = 2'd2
  } mode_e;

  typedef struct packed {
    logic restart;
    logic memLoad;
  } ctlStrobe_t;
endpackage

// File: rtl/clk_fsdiv_div.sv
`timescale 1ns/1ps
module clk_fsdiv_div
  import clk_fsdiv_pkg::*;
(
  input  logic   clk,
  input  logic   restart,
  input  logic   reload,
  input  ratio_t newRatio,
  output logic   clkOut,
  output logic   atEnd
);
  ratio_t curN, cnt, nextN, nextCnt;
  logic   posQ, negQ, runQ, gateEn;
  logic   isOdd, isBypass, lastCount;

  assign lastCount = (cnt == curN - ratio_t'(1));

  always_comb begin
    nextN   = reload ? newRatio : curN;
    nextCnt = (reload || lastCount) ? '0 : cnt + ratio_t'(1);
  end

  // High phase covers the first half of the count (rounded down).
  always_ff @(posedge clk) begin
    if (restart) begin
      curN <= newRatio;
      cnt  <= newRatio - ratio_t'(1);
      posQ <= 1'b0;
      runQ <= 1'b0;
    end else begin
      curN <= nextN;
      cnt  <= nextCnt;
      posQ <= (nextCnt < (nextN >> 1));
      runQ <= 1'b1;
    end
  end

  // Half-cycle extension for odd ratios, and a glitch-free gate for bypass.
  always_ff @(negedge clk) begin
    negQ   <= posQ;
    gateEn <= runQ;
  end

  assign isOdd    = curN[0];
  assign isBypass = (curN == ratio_t'(1));
  assign clkOut   = isBypass ? (clk & gateEn) : (isOdd ? (posQ | negQ) : posQ);
  assign atEnd    = lastCount && !posQ && !negQ;
endmodule

// File: rtl/clk_fsdiv_ctl.sv
`timescale 1ns/1ps
module clk_fsdiv_ctl
  import clk_fsdiv_pkg::*;
#(
  parameter int CPU_SLOW_DIV = 6,
  parameter int CPU_MID_DIV  = 4,
  parameter int CPU_FAST_DIV = 3,
  parameter int MEM_STD_DIV  = 4,
  parameter int MEM_FAST_DIV = 3,
  parameter int HUB_DIV      = 6,
  parameter int PCI_DIV      = 12,
  parameter int APIC_DIV     = 12,
  parameter int USB_DIV      = 8,
  parameter int REF_DIV      = 28
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      fsSel,
  input  logic            sdramFast,
  input  logic [NGRP-1:0] atEnd,
  output ctlStrobe_t      strobe,
  output ratioSet_t       ratio,
  output logic            outEn
);
  localparam logic [NGRP-1:0] MEM_SEL = NGRP'(1) << G_MEM;

  mode_e      mode;
  logic [1:0] speedSel;
  logic [3:0] key, keyQ;
  ratio_t     memActive;
  logic       memAtEnd;

  always_comb begin
    speedSel = {fsSel[0], fsSel[1]};
    if (fsSel[2])      mode = MODE_RUN;
    else if (fsSel[0]) mode = MODE_TEST;
    else               mode = MODE_TRI;
    key = {mode, (mode == MODE_RUN) ? speedSel : 2'b00};
  end

  always_comb begin
    ratio = '0;
    case (mode)
      MODE_TEST: begin
        ratio[G_CPU]  = T_CPU;
        ratio[G_MEM]  = T_MEM;
        ratio[G_HUB]  = T_HUB;
        ratio[G_PCI]  = T_PCI;
        ratio[G_USB]  = T_USB;
        ratio[G_REF]  = T_REF;
        ratio[G_APIC] = T_APIC;
      end
      MODE_RUN: begin
        ratio[G_HUB]  = ratio_t'(HUB_DIV);
        ratio[G_PCI]  = ratio_t'(PCI_DIV);
        ratio[G_USB]  = ratio_t'(USB_DIV);
        ratio[G_REF]  = ratio_t'(REF_DIV);
        ratio[G_APIC] = ratio_t'(APIC_DIV);
        case (speedSel)
          2'b00: begin
            ratio[G_CPU] = ratio_t'(CPU_SLOW_DIV);
            ratio[G_MEM] = ratio_t'(MEM_STD_DIV);
          end
          2'b10: begin
            ratio[G_CPU] = ratio_t'(CPU_MID_DIV);
            ratio[G_MEM] = ratio_t'(MEM_STD_DIV);
          end
          2'b01: begin
            ratio[G_CPU] = ratio_t'(CPU_FAST_DIV);
            ratio[G_MEM] = ratio_t'(MEM_FAST_DIV);
          end
          default: begin
            ratio[G_CPU] = ratio_t'(CPU_FAST_DIV);
            ratio[G_MEM] = sdramFast ? ratio_t'(MEM_FAST_DIV) : ratio_t'(MEM_STD_DIV);
          end
        endcase
      end
      default: ratio = '0;
    endcase
  end

  assign outEn    = (mode != MODE_TRI);
  assign memAtEnd = |(atEnd & MEM_SEL);

  always_comb begin
    strobe.restart = rst || (mode == MODE_TRI) || (key != keyQ);
    strobe.memLoad = !strobe.restart && (ratio[G_MEM] != memActive) && memAtEnd;
  end

  always_ff @(posedge clk) begin
    keyQ <= key;
    if (strobe.restart || strobe.memLoad) memActive <= ratio[G_MEM];
  end
endmodule

// File: rtl/clk_fsdiv_path.sv
`timescale 1ns/1ps
module clk_fsdiv_path
  import clk_fsdiv_pkg::*;
(
  input  logic            clk,
  input  ctlStrobe_t      strobe,
  input  ratioSet_t       ratio,
  output logic [NGRP-1:0] grpClk,
  output logic [NGRP-1:0] atEnd
);
  for (genvar g = 0; g < NGRP; g++) begin : g_div
    logic reloadSel;
    if (g == G_MEM) begin : g_mem
      assign reloadSel = strobe.memLoad;
    end else begin : g_fixed
      assign reloadSel = 1'b0;
    end
    clk_fsdiv_div u_div (
      .clk      (clk),
      .restart  (strobe.restart),
      .reload   (reloadSel),
      .newRatio (ratio[g]),
      .clkOut   (grpClk[g]),
      .atEnd    (atEnd[g])
    );
  end
endmodule

// File: rtl/clk_fsdiv.sv
`timescale 1ns/1ps
module clk_fsdiv
  import clk_fsdiv_pkg::*;
#(
  parameter int CPU_SLOW_DIV = 6,
  parameter int CPU_MID_DIV  = 4,
  parameter int CPU_FAST_DIV = 3,
  parameter int MEM_STD_DIV  = 4,
  parameter int MEM_FAST_DIV = 3,
  parameter int HUB_DIV      = 6,
  parameter int PCI_DIV      = 12,
  parameter int APIC_DIV     = 12,
  parameter int USB_DIV      = 8,
  parameter int REF_DIV      = 28
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] fsSel,
  input  logic       sdramFast,
  output logic       cpuClk,
  output logic       sdramClk,
  output logic       hubClk,
  output logic       pciClk,
  output logic       usbClk,
  output logic       refClk,
  output logic       apicClk,
  output logic       outEn
);
  ctlStrobe_t      strobe;
  ratioSet_t       ratio;
  logic [NGRP-1:0] grpClk, atEnd;

  clk_fsdiv_ctl #(
    .CPU_SLOW_DIV (CPU_SLOW_DIV), .CPU_MID_DIV (CPU_MID_DIV), .CPU_FAST_DIV (CPU_FAST_DIV),
    .MEM_STD_DIV  (MEM_STD_DIV),  .MEM_FAST_DIV (MEM_FAST_DIV),
    .HUB_DIV (HUB_DIV), .PCI_DIV (PCI_DIV), .APIC_DIV (APIC_DIV),
    .USB_DIV (USB_DIV), .REF_DIV (REF_DIV)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .fsSel     (fsSel),
    .sdramFast (sdramFast),
    .atEnd     (atEnd),
    .strobe    (strobe),
    .ratio     (ratio),
    .outEn     (outEn)
  );

  clk_fsdiv_path u_path (
    .clk    (clk),
    .strobe (strobe),
    .ratio  (ratio),
    .grpClk (grpClk),
    .atEnd  (atEnd)
  );

  assign cpuClk   = grpClk[G_CPU];
  assign sdramClk = grpClk[G_MEM];
  assign hubClk   = grpClk[G_HUB];
  assign pciClk   = grpClk[G_PCI];
  assign usbClk   = grpClk[G_USB];
  assign refClk   = grpClk[G_REF];
  assign apicClk  = grpClk[G_APIC];
endmodule

// File: rtl/clk_fsdiv_chk.sv
`timescale 1ns/1ps
module clk_fsdiv_chk
  import clk_fsdiv_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] fsSel,
  input logic       cpuClk,
  input logic       sdramClk,
  input logic       hubClk,
  input logic       pciClk,
  input logic       usbClk,
  input logic       refClk,
  input logic       apicClk,
  input ctlStrobe_t strobe
);
  logic triNow;
  assign triNow = !fsSel[2] && !fsSel[0];

  // R1
  tri_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (triNow && $past(triNow)) |->
      !(cpuClk || sdramClk || hubClk || pciClk || usbClk || refClk || apicClk));

  // R8
  mem_load_low_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.memLoad |-> !sdramClk);

  // R8
  run_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (fsSel[2] && $stable(fsSel)) |-> !strobe.restart);

  // R7
  pci_hub_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pciClk) |-> $rose(hubClk));

  // R7
  apic_pci_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(apicClk) |-> $rose(pciClk));
endmodule

bind clk_fsdiv clk_fsdiv_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .fsSel    (fsSel),
  .cpuClk   (cpuClk),
  .sdramClk (sdramClk),
  .hubClk   (hubClk),
  .pciClk   (pciClk),
  .usbClk   (usbClk),
  .refClk   (refClk),
  .apicClk  (apicClk),
  .strobe   (strobe)
);

// File: tb/clk_fsdiv_bench.sv
`timescale 1ns/1ps
module clk_fsdiv_bench;
  localparam int NG = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] fsSel = 3'b101;
  logic       sdramFast = 1'b0;
  logic cpuClk, sdramClk, hubClk, pciClk, usbClk, refClk, apicClk, outEn;

  clk_fsdiv u_clk_fsdiv (
    .clk (clk), .rst (rst), .fsSel (fsSel), .sdramFast (sdramFast),
    .cpuClk (cpuClk), .sdramClk (sdramClk), .hubClk (hubClk), .pciClk (pciClk),
    .usbClk (usbClk), .refClk (refClk), .apicClk (apicClk), .outEn (outEn)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  string grpName [NG] = '{"cpu", "sdram", "hub", "pci", "usb", "ref", "apic"};

  // measurement state, in half-period samples
  int sIdx = 0;
  bit prevV [NG];
  bit haveRise [NG];
  int riseAt [NG];
  int highRun [NG];
  int lastPer [NG];
  int lastHigh [NG];
  int cycCount [NG];
  int highSeen [NG];
  bit armed [NG];
  int expPer [NG];
  int badCyc [NG];
  int alignErr = 0;

  typedef struct {
    int    grp;
    int    ratio;
    string tag;
  } expItem_t;
  expItem_t sb [$];
  bit busy = 1'b0;

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic takeSample();
    logic [NG-1:0] v;
    bit rose [NG];
    v = {apicClk, refClk, usbClk, pciClk, hubClk, sdramClk, cpuClk};
    for (int g = 0; g < NG; g++) begin
      rose[g] = (v[g] === 1'b1) && !prevV[g];
      if (v[g] === 1'b1) highSeen[g]++;
      if (rose[g]) begin
        if (haveRise[g]) begin
          lastPer[g]  = sIdx - riseAt[g];
          lastHigh[g] = highRun[g];
          cycCount[g]++;
          if (armed[g] && (lastPer[g] != expPer[g] || lastHigh[g] != expPer[g] / 2))
            badCyc[g]++;
        end
        haveRise[g] = 1'b1;
        riseAt[g]   = sIdx;
        highRun[g]  = 0;
      end
      if (v[g] === 1'b1) highRun[g]++;
      prevV[g] = (v[g] === 1'b1);
    end
    // R7: pci edge with hub edge, apic edge with pci edge
    if (rose[3] && !rose[2]) alignErr++;
    if (rose[6] != rose[3]) alignErr++;
    sIdx++;
  endtask

  initial begin
    forever begin
      @(posedge clk); #1.25; takeSample();
      @(negedge clk); #1.25; takeSample();
    end
  end

  // scoreboard monitor: pops expected ratios, compares two fresh cycles
  initial begin
    forever begin
      expItem_t it;
      int base;
      while (sb.size() == 0) @(posedge clk);
      it = sb.pop_front();
      busy = 1'b1;
      base = cycCount[it.grp];
      while (cycCount[it.grp] < base + 2) @(posedge clk);
      checkEq(it.tag, {grpName[it.grp], " period"}, lastPer[it.grp], 2 * it.ratio);
      checkEq("R6", {grpName[it.grp], " high time"}, lastHigh[it.grp], it.ratio);
      busy = 1'b0;
    end
  end

  task automatic applyCfg(input logic [2:0] fs, input logic fast);
    @(posedge clk); #1;
    fsSel = fs;
    sdramFast = fast;
    repeat (6) @(posedge clk);
    #1;
    for (int g = 0; g < NG; g++) begin
      haveRise[g] = 1'b0;
      highSeen[g] = 0;
    end
  endtask

  task automatic pushExp(input int grp, input int ratio, input string tag);
    expItem_t it;
    it.grp = grp; it.ratio = ratio; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drain();
    while (sb.size() != 0 || busy) @(posedge clk);
  endtask

  task automatic expectRun(input int cpuN, input int memN, input string cpuTag, input string memTag);
    pushExp(0, cpuN, cpuTag);
    pushExp(1, memN, memTag);
    pushExp(2, 6, "R5");
    pushExp(3, 12, "R5");
    pushExp(4, 8, "R5");
    pushExp(5, 28, "R5");
    pushExp(6, 12, "R5");
    drain();
  endtask

  task automatic expectTest();
    pushExp(0, 2, "R2"); pushExp(1, 2, "R2"); pushExp(2, 3, "R2"); pushExp(3, 6, "R2");
    pushExp(4, 2, "R2"); pushExp(5, 1, "R2"); pushExp(6, 6, "R2");
    drain();
  endtask

  task automatic quietCheck(input string tag);
    int total;
    repeat (24) @(posedge clk);
    total = 0;
    for (int g = 0; g < NG; g++) total += highSeen[g];
    checkEq(tag, "high samples while quiet", total, 0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run incomplete actual=timeout expected=done");
    finishRun();
  end

  initial begin
    // R9: reset holds all outputs low
    repeat (8) @(posedge clk);
    #1;
    for (int g = 0; g < NG; g++) highSeen[g] = 0;
    quietCheck("R9");
    @(posedge clk); #1;
    rst = 1'b0;

    // R3 R4 R5: code 00
    applyCfg(3'b100, 1'b0);
    checkEq("R1", "outEn in run mode", int'(outEn), 1);
    expectRun(6, 4, "R3", "R4");
    // code 10, sdramFast ignored
    applyCfg(3'b101, 1'b1);
    expectRun(4, 4, "R3", "R4");
    // code 01, sdramFast ignored, odd ratio 3
    applyCfg(3'b110, 1'b0);
    expectRun(3, 3, "R3", "R4");
    // code 11 slow memory
    applyCfg(3'b111, 1'b0);
    expectRun(3, 4, "R3", "R4");

    // R8: switch memory ratio, other groups must not be disturbed
    for (int g = 0; g < NG; g++) begin
      badCyc[g] = 0;
      armed[g] = (g != 1);
    end
    expPer[0] = 6; expPer[2] = 12; expPer[3] = 24; expPer[4] = 16;
    expPer[5] = 56; expPer[6] = 24;
    @(posedge clk); #1;
    sdramFast = 1'b1;
    repeat (150) @(posedge clk);
    pushExp(1, 3, "R4");
    drain();
    begin
      int bad;
      bad = 0;
      for (int g = 0; g < NG; g++) bad += badCyc[g];
      checkEq("R8", "disturbed cycles on other groups", bad, 0);
    end
    @(posedge clk); #1;
    sdramFast = 1'b0;
    repeat (150) @(posedge clk);
    pushExp(1, 4, "R8");
    pushExp(0, 3, "R8");
    drain();
    begin
      int bad;
      bad = 0;
      for (int g = 0; g < NG; g++) bad += badCyc[g];
      checkEq("R8", "disturbed cycles on return", bad, 0);
    end
    for (int g = 0; g < NG; g++) armed[g] = 1'b0;

    // R2: test mode, fsSel[1] both values
    applyCfg(3'b001, 1'b0);
    checkEq("R2", "outEn in test mode", int'(outEn), 1);
    expectTest();
    applyCfg(3'b011, 1'b1);
    expectTest();

    // R1: quiet mode, fsSel[1] both values
    applyCfg(3'b000, 1'b0);
    checkEq("R1", "outEn in quiet mode", int'(outEn), 0);
    quietCheck("R1");
    applyCfg(3'b010, 1'b1);
    checkEq("R1", "outEn in quiet mode fs1", int'(outEn), 0);
    quietCheck("R1");

    // back to run after quiet
    applyCfg(3'b100, 1'b0);
    expectRun(6, 4, "R3", "R4");

    checkEq("R7", "edge alignment errors", alignErr, 0);
    finishRun();
  end
endmodule